// File: doc/BRIEF.md
# Supply Fault Output Sequencer

This block turns two sampled comparator flags into two reset-style fault outputs. One flag reports that a monitored rail sits below its low limit; the other reports that it sits above its high limit. Each flag first passes through its own integrating filter, so brief transients are rejected. Each output then goes through its own retriggerable hold-off timer. An asserted output is held for a programmable number of clock cycles after its filtered fault clears. Three other rules sit on top of the timers: a sticky overvoltage latch controlled by a mode input, an output-disable input, and a supply-lockout input. They act in a fixed order of priority.

The undervoltage output (`uvOutN`) is active-low. The polarity of the overvoltage output is chosen by a parameter; it is active-low by default. The hold-off length comes in on a port as a cycle count. A bypass strap removes the hold-off, and each output then follows its filtered flag.

Top module: `supply_fault_seq`

## Requirements
- R1: Reset forces `uvOutN` to 0 and the overvoltage output to its deasserted level (1 with the default `OV_ACT_HIGH=0`). It also clears both integrators, both timers and the sticky latch, so a fault present at the moment of reset has no carry-over.
- R2: Each integrator is a saturating up/down counter with full scale `FILT_MAX`. A raw flag that is high for fewer than `FILT_MAX` consecutive cycles, and then low long enough to drain the counter, never changes an output.
- R3: A raw undervoltage flag that stays high asserts `uvOutN` (0) after exactly `FILT_MAX+1` clock edges: `FILT_MAX` edges to fill the integrator and one to register the output.
- R4: After the filtered undervoltage flag clears, `uvOutN` stays 0 and returns to 1 on the `timeoutLen+1`-th edge after the filter cleared. Measured from the raw flag falling, this is `FILT_MAX+timeoutLen+1` edges. The same hold-off applies after reset.
- R5: If the filtered fault returns while the hold-off is running, the timer restarts from zero, and the full hold-off is counted again from the next clear.
- R6: With `timerBypass` high, an output releases one edge after its filtered flag clears.
- R7: With `ovTrack` high, the overvoltage output asserts and releases with the same timing as R3/R4, independently of the undervoltage output.
- R8: With `ovTrack` low, a filtered overvoltage sets a sticky assertion that remains after the fault and the hold-off are over. It clears on the first edge with `ovTrack` high.
- R9: Taking `ovTrack` low while the overvoltage hold-off is still running latches the overvoltage output asserted.
- R10: While `lockout` is high, `uvOutN` is 0 and the overvoltage output is deasserted and cleared (sticky latch included), one edge after `lockout` is sampled high. An overvoltage during lockout is ignored.
- R11: When `lockout` falls, `uvOutN` releases on the `timeoutLen+1`-th edge, as for a cleared undervoltage.
- R12: With `outDisable` high, both outputs are deasserted whatever the faults. The one exception is lockout: `uvOutN` follows the registered lockout with no hold-off, releasing one edge after `lockout` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| underFlag | input | 1 | Raw undervoltage comparator flag, active high |
| overFlag | input | 1 | Raw overvoltage comparator flag, active high |
| lockout | input | 1 | Supply lockout, active high |
| ovTrack | input | 1 | High: overvoltage output tracks like undervoltage and clears the latch; low: sticky |
| outDisable | input | 1 | Forces both outputs deasserted, except undervoltage during lockout |
| timerBypass | input | 1 | Skips the hold-off period |
| timeoutLen | input | CNT_W | Hold-off length in clock cycles |
| uvOutN | output | 1 | Undervoltage output, active low |
| ovOut | output | 1 | Overvoltage output, polarity set by OV_ACT_HIGH |

## Verification
The bench pins each release to its exact edge, one cycle before and one cycle at. A design with the hold-off off by one, or one that releases early because it kept the count from before a retriggering fault, therefore misses the check. The bench also drops the latch mode while the overvoltage timer is still mid-count. A design that latches only on a live fault would let the output release there. It asserts lockout while an overvoltage is live, which catches a design that lets OV through during lockout. It also asserts lockout while outputs are disabled, where a design that applied the hold-off would keep undervoltage asserted long after lockout ends.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_UV  = 0;
  localparam int CH_OV  = 1;

  // Control -> datapath timer strobes, one bit per channel
  typedef struct packed {
    logic [NUM_CH-1:0] tmrClr;
    logic [NUM_CH-1:0] tmrRun;
  } sfs_strobe_t;

  // Datapath -> control status, one bit per channel
  typedef struct packed {
    logic [NUM_CH-1:0] filt;
    logic [NUM_CH-1:0] done;
  } sfs_status_t;

endpackage

// File: rtl/sfs_integrator.sv
module sfs_integrator #(
  parameter int FILT_MAX = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);

  localparam int W = (FILT_MAX < 2) ? 1 : $clog2(FILT_MAX + 1);
  localparam logic [W-1:0] FULL = W'(FILT_MAX);

  logic [W-1:0] level;
  logic [W-1:0] levelNext;

  always_comb begin
    levelNext = level;
    if (rawIn && (level != FULL))
      levelNext = level + 1'b1;
    else if (!rawIn && (level != '0))
      levelNext = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level   <= '0;
      filtOut <= 1'b0;
    end else begin
      level <= levelNext;
      if (levelNext == FULL)
        filtOut <= 1'b1;
      else if (levelNext == '0)
        filtOut <= 1'b0;
    end
  end

endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int FILT_MAX = 4,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawFlags,
  input  logic [CNT_W-1:0]  timeoutLen,
  input  sfs_strobe_t       strobe,
  output sfs_status_t       status
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] holdCnt;

    sfs_integrator #(.FILT_MAX(FILT_MAX)) u_integ (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawFlags[ch]),
      .filtOut(status.filt[ch])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        holdCnt <= '0;
      else if (strobe.tmrClr[ch])
        holdCnt <= '0;
      else if (strobe.tmrRun[ch] && (holdCnt != CNT_TOP))
        holdCnt <= holdCnt + 1'b1;
    end

    assign status.done[ch] = (holdCnt >= timeoutLen);
  end

endmodule

// File: rtl/sfs_control.sv
module sfs_control
  import sfs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockout,
  input  logic        ovTrack,
  input  logic        outDisable,
  input  logic        timerBypass,
  input  sfs_status_t status,
  output sfs_strobe_t strobe,
  output logic        uvActive,
  output logic        ovActive
);

  logic uvHeld, ovHeld, ovSticky, lockQ;
  logic uvHeldNext, ovHeldNext, ovStickyNext;

  always_comb begin
    strobe     = '0;
    uvHeldNext = uvHeld;
    // Undervoltage channel: lockout and live fault both hold and reset the timer
    if (lockout || status.filt[CH_UV]) begin
      uvHeldNext            = 1'b1;
      strobe.tmrClr[CH_UV]  = 1'b1;
    end else if (uvHeld) begin
      if (timerBypass || status.done[CH_UV]) begin
        uvHeldNext           = 1'b0;
        strobe.tmrClr[CH_UV] = 1'b1;
      end else begin
        strobe.tmrRun[CH_UV] = 1'b1;
      end
    end

    // Overvoltage channel: lockout clears everything and blocks assertion
    ovHeldNext   = ovHeld;
    ovStickyNext = ovSticky;
    if (lockout) begin
      ovHeldNext           = 1'b0;
      ovStickyNext         = 1'b0;
      strobe.tmrClr[CH_OV] = 1'b1;
    end else begin
      if (status.filt[CH_OV]) begin
        ovHeldNext           = 1'b1;
        strobe.tmrClr[CH_OV] = 1'b1;
      end else if (ovHeld) begin
        if (timerBypass || status.done[CH_OV]) begin
          ovHeldNext           = 1'b0;
          strobe.tmrClr[CH_OV] = 1'b1;
        end else begin
          strobe.tmrRun[CH_OV] = 1'b1;
        end
      end
      if (ovTrack)
        ovStickyNext = 1'b0;
      else if (status.filt[CH_OV] || ovHeld)
        ovStickyNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uvHeld   <= 1'b1;
      ovHeld   <= 1'b0;
      ovSticky <= 1'b0;
      lockQ    <= 1'b0;
    end else begin
      uvHeld   <= uvHeldNext;
      ovHeld   <= ovHeldNext;
      ovSticky <= ovStickyNext;
      lockQ    <= lockout;
    end
  end

  // Disable overrides; during disable UV mirrors the registered lockout only
  assign uvActive = outDisable ? lockQ : uvHeld;
  assign ovActive = !outDisable && (ovHeld || ovSticky);

endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq
  import sfs_pkg::*;
#(
  parameter int FILT_MAX    = 4,
  parameter int CNT_W       = 16,
  parameter bit OV_ACT_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             underFlag,
  input  logic             overFlag,
  input  logic             lockout,
  input  logic             ovTrack,
  input  logic             outDisable,
  input  logic             timerBypass,
  input  logic [CNT_W-1:0] timeoutLen,
  output logic             uvOutN,
  output logic             ovOut
);

  sfs_strobe_t strobe;
  sfs_status_t status;
  logic        uvActive, ovActive;
  logic [NUM_CH-1:0] rawFlags;

  assign rawFlags[CH_UV] = underFlag;
  assign rawFlags[CH_OV] = overFlag;

  sfs_datapath #(.FILT_MAX(FILT_MAX), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rawFlags  (rawFlags),
    .timeoutLen(timeoutLen),
    .strobe    (strobe),
    .status    (status)
  );

  sfs_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lockout    (lockout),
    .ovTrack    (ovTrack),
    .outDisable (outDisable),
    .timerBypass(timerBypass),
    .status     (status),
    .strobe     (strobe),
    .uvActive   (uvActive),
    .ovActive   (ovActive)
  );

  assign uvOutN = !uvActive;

  if (OV_ACT_HIGH) begin : g_ov_hi
    assign ovOut = ovActive;
  end else begin : g_ov_lo
    assign ovOut = !ovActive;
  end

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter bit OV_ACT_HIGH = 1'b0
) (
  input logic clk,
  input logic rstN,
  input logic lockout,
  input logic ovTrack,
  input logic outDisable,
  input logic uvOutN,
  input logic ovOut
);

  logic ovOn;
  assign ovOn = OV_ACT_HIGH ? ovOut : !ovOut;

  // R10
  lock_uv_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockout |=> !uvOutN);

  // R10
  lock_ov_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockout |=> !ovOn);

  // R11
  lock_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvOutN) |-> !$past(lockout));

  // R12
  dis_ov_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> !ovOn);

  // R12
  dis_uv_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockout |=> (uvOutN || !outDisable));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovOn && !ovTrack && !lockout) |=> (ovOn || outDisable));

endmodule

bind supply_fault_seq sfs_checker #(.OV_ACT_HIGH(OV_ACT_HIGH)) u_sfs_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lockout   (lockout),
  .ovTrack   (ovTrack),
  .outDisable(outDisable),
  .uvOutN    (uvOutN),
  .ovOut     (ovOut)
);

// File: tb/test_supply_fault_seq.sv
module test_supply_fault_seq;

  localparam int FILT = 3;
  localparam int LEN  = 5;
  localparam int CW   = 16;
  localparam int NV   = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic underFlag = 1'b0, overFlag = 1'b0, lockout = 1'b0;
  logic ovTrack = 1'b1, outDisable = 1'b0, timerBypass = 1'b0;
  logic [CW-1:0] timeoutLen = CW'(LEN);
  logic uvOutN, ovOut;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  supply_fault_seq #(.FILT_MAX(FILT), .CNT_W(CW), .OV_ACT_HIGH(1'b0)) i_supply_fault_seq (
    .clk(clk), .rstN(rstN), .underFlag(underFlag), .overFlag(overFlag),
    .lockout(lockout), .ovTrack(ovTrack), .outDisable(outDisable),
    .timerBypass(timerBypass), .timeoutLen(timeoutLen),
    .uvOutN(uvOutN), .ovOut(ovOut)
  );

  // [19:16] req, [15] under, [14] over, [13] lockout, [12] track, [11] disable,
  // [10] bypass, [9:2] edges to wait, [1] expected uvOutN, [0] expected ovOut (active low)
  localparam logic [19:0] VEC [NV] = '{
    {4'd4,  6'b000100, 8'd5,  2'b01},  // R4 hold-off after reset
    {4'd4,  6'b000100, 8'd1,  2'b11},  // R4
    {4'd2,  6'b100100, 8'd2,  2'b11},  // R2 short pulse
    {4'd2,  6'b000100, 8'd4,  2'b11},  // R2 rejected
    {4'd3,  6'b100100, 8'd3,  2'b11},  // R3 not yet
    {4'd3,  6'b100100, 8'd1,  2'b01},  // R3 asserted
    {4'd3,  6'b100100, 8'd3,  2'b01},  // R3
    {4'd4,  6'b000100, 8'd8,  2'b01},  // R4 one before release
    {4'd4,  6'b000100, 8'd1,  2'b11},  // R4 released
    {4'd5,  6'b100100, 8'd4,  2'b01},  // R5
    {4'd5,  6'b000100, 8'd5,  2'b01},  // R5 timer mid-count
    {4'd5,  6'b100100, 8'd3,  2'b01},  // R5 fault returns
    {4'd5,  6'b000100, 8'd8,  2'b01},  // R5 full hold-off again
    {4'd5,  6'b000100, 8'd1,  2'b11},  // R5
    {4'd6,  6'b100101, 8'd4,  2'b01},  // R6
    {4'd6,  6'b000101, 8'd3,  2'b01},  // R6 filter just cleared
    {4'd6,  6'b000101, 8'd1,  2'b11},  // R6 no hold-off
    {4'd7,  6'b010100, 8'd3,  2'b11},  // R7
    {4'd7,  6'b010100, 8'd1,  2'b10},  // R7 OV only
    {4'd7,  6'b000100, 8'd8,  2'b10},  // R7
    {4'd7,  6'b000100, 8'd1,  2'b11},  // R7 released
    {4'd8,  6'b010000, 8'd4,  2'b10},  // R8
    {4'd8,  6'b000000, 8'd12, 2'b10},  // R8 sticky
    {4'd8,  6'b000100, 8'd1,  2'b11},  // R8 cleared by track
    {4'd9,  6'b010100, 8'd4,  2'b10},  // R9
    {4'd9,  6'b000100, 8'd5,  2'b10},  // R9 timer running
    {4'd9,  6'b000000, 8'd10, 2'b10},  // R9 latched mid hold-off
    {4'd9,  6'b000100, 8'd1,  2'b11},  // R9
    {4'd10, 6'b010100, 8'd4,  2'b10},  // R10
    {4'd10, 6'b011100, 8'd1,  2'b01},  // R10 lockout wins
    {4'd10, 6'b001100, 8'd4,  2'b01},  // R10
    {4'd11, 6'b000100, 8'd5,  2'b01},  // R11 hold-off after lockout
    {4'd11, 6'b000100, 8'd1,  2'b11},  // R11
    {4'd12, 6'b110110, 8'd6,  2'b11},  // R12 disabled
    {4'd12, 6'b111110, 8'd1,  2'b01},  // R12 lockout while disabled
    {4'd12, 6'b000110, 8'd1,  2'b11}   // R12 no hold-off
  };

  task automatic check(input string req, input logic expUv, input logic expOv);
    total++;
    if (uvOutN !== expUv || ovOut !== expOv) begin
      bad++;
      $display("FAIL %s: uvOutN=%b ovOut=%b expected uvOutN=%b ovOut=%b at %0t",
               req, uvOutN, ovOut, expUv, expOv, $time);
    end
  endtask

  task automatic runAll();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1", 1'b0, 1'b1);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      {underFlag, overFlag, lockout, ovTrack, outDisable, timerBypass} = VEC[i][15:10];
      repeat (int'(VEC[i][9:2])) @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d step %0d", VEC[i][19:16], i), VEC[i][1], VEC[i][0]);
    end

    // Directed: reset in the middle of live faults (R1)
    {underFlag, overFlag, lockout, ovTrack, outDisable, timerBypass} = 6'b110100;
    repeat (FILT + 1) @(posedge clk);
    @(negedge clk);
    check("R3 pre-reset", 1'b0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 in reset", 1'b0, 1'b1);
    underFlag = 1'b0;
    overFlag  = 1'b0;
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 filters cleared", 1'b0, 1'b1);
    repeat (LEN) @(posedge clk);
    @(negedge clk);
    check("R1 hold-off after reset", 1'b1, 1'b1);

    // Directed: overvoltage ignored during lockout (R10)
    lockout  = 1'b1;
    overFlag = 1'b1;
    repeat (FILT + 3) @(posedge clk);
    @(negedge clk);
    check("R10 OV blocked", 1'b0, 1'b1);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule